// File: doc/BRIEF.md
# Amplifier Channel Protection Controller

This block collects the protection flags of a four-channel class-D power stage and decides which channels must leave the output bridge floating (Hi-Z). It also drives the two shared active-low status lines. Each channel has its own handling for a peak overcurrent, a sustained DC offset, the cycle-by-cycle current limit and 100 % duty clipping. Die temperature is handled globally.

Each fault type recovers in its own way. An overcurrent trip clears by itself once the short has been gone for one second. A DC-offset trip stays latched until the part passes through standby. An overtemperature shutdown follows its flag and needs no timer. All timing comes from a 1 ms tick input, and every window is counted in ticks of that input.

Top module: `amp_prot_ctrl`

## Requirements
- R1: When `oc_peak_i[c]` is high at a clock edge, `hiz_o[c]` reads 1 after that edge. No other channel's `hiz_o` bit changes because of it, and `fault_no` reads 0.
- R2: An overcurrent trip on a channel clears on the RECOVER_TICKS-th tick (1000 by default) counted while `oc_peak_i[c]` is low. A reappearance of `oc_peak_i[c]` before then restarts the count from zero.
- R3: `cbc_lim_i` has no effect on `hiz_o` or `fault_no`. Every channel keeps playing.
- R4: A channel latches off (`hiz_o[c]`=1, `fault_no`=0) on the DC_TRIP_TICKS-th consecutive tick (1000 by default) at which `dc_off_i[c]` is high. Any cycle with `dc_off_i[c]` low resets that count.
- R5: A DC latch stays set after the offset disappears. Only `standby_i` high at a clock edge clears it. If the offset is still present after standby is released, the channel trips again after another full window.
- R6: `clip_warn_no` reads 0 in the cycle after any `clip_i` bit is high, and returns to 1 one cycle after all bits are low (unless a warning is active).
- R7: `ot_warn_i` high drives `clip_warn_no` to 0 one cycle later. It has no effect on `hiz_o` or `fault_no`.
- R8: `ot_sd_i` high forces all `hiz_o` bits to 1 and `fault_no` to 0 one cycle later. Both return on their own one cycle after the flag falls.
- R9: `fault_no` is 0 exactly when any overcurrent trip, any DC latch or the shutdown state is active.
- R10: After reset, `hiz_o` is all zeros and both `fault_no` and `clip_warn_no` are 1 (released).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every 1 ms |
| standby_i | input | 1 | High while the amplifier sits in standby; clears DC latches |
| oc_peak_i | input | NUM_CH | Per-channel peak overcurrent flag |
| cbc_lim_i | input | NUM_CH | Per-channel cycle-by-cycle current limit active |
| dc_off_i | input | NUM_CH | Per-channel output DC offset above trip level |
| clip_i | input | NUM_CH | Per-channel PWM at 100 % duty |
| ot_warn_i | input | 1 | Die temperature above warning level |
| ot_sd_i | input | 1 | Die temperature above shutdown level |
| hiz_o | output | NUM_CH | Per-channel request to float the output bridge |
| fault_no | output | 1 | Fault line, active low (open-drain: 1 = released) |
| clip_warn_no | output | 1 | Clip / temperature-warning line, active low (open-drain: 1 = released) |

## Verification
The hardest situation to reach is the boundary of the one-second windows. The stimulus has to place a fault reappearance, or a one-cycle gap in the DC offset, within a few ticks of expiry. Random flag toggling almost never lands there. Directed sequences therefore count ticks exactly: they stop one tick short of expiry to confirm the state still holds, then take one more tick to confirm the change, and they interrupt a recovery halfway to prove the restart. A long random phase with rare overcurrent pulses, slow DC and temperature toggles and occasional standby pulses then runs against a bench model, so that trips, recoveries and latches overlap across channels.

// File: rtl/amp_prot_pkg.sv
package amp_prot_pkg;
  localparam int unsigned DEF_NUM_CH = 4;
  localparam int unsigned DEF_WINDOW = 1000;

  typedef struct packed {
    logic shutdown;
    logic warn;
    logic clip;
  } glob_flags_t;
endpackage

// File: rtl/prot_oc_chan.sv
module prot_oc_chan #(
  parameter int unsigned RECOVER_TICKS = 1000,
  localparam int unsigned CW = $clog2(RECOVER_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic oc_peak_i,
  input  logic cbc_i,
  output logic trip_o
);
  logic          trip_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= 1'b0;
      cnt_q  <= '0;
    end else if (oc_peak_i) begin
      trip_q <= 1'b1;
      cnt_q  <= '0;
    end else if (trip_q && tick_i) begin
      if (cnt_q == CW'(RECOVER_TICKS - 1)) begin
        trip_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign trip_o = trip_q;

  p_peak_trips_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_peak_i |=> trip_q);
  p_clear_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trip_q) |-> ($past(tick_i) && !$past(oc_peak_i)));
  p_cbc_no_trip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cbc_i && !oc_peak_i && !trip_q) |=> !trip_q);
endmodule

// File: rtl/prot_dc_chan.sv
module prot_dc_chan #(
  parameter int unsigned TRIP_TICKS = 1000,
  localparam int unsigned CW = $clog2(TRIP_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic standby_i,
  input  logic dc_off_i,
  output logic latch_o
);
  logic          latch_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      cnt_q   <= '0;
    end else if (standby_i) begin
      latch_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!dc_off_i) begin
      cnt_q <= '0;
    end else if (!latch_q && tick_i) begin
      if (cnt_q == CW'(TRIP_TICKS - 1)) begin
        latch_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign latch_o = latch_q;

  p_latch_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |-> ($past(tick_i) && $past(dc_off_i)));
  p_standby_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> !latch_q);
  p_latch_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !standby_i) |=> latch_q);
endmodule

// File: rtl/prot_global.sv
module prot_global
  import amp_prot_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ot_warn_i,
  input  logic              ot_sd_i,
  input  logic [NUM_CH-1:0] clip_i,
  output glob_flags_t       flags_o
);
  glob_flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else begin
      flags_q.shutdown <= ot_sd_i;
      flags_q.warn     <= ot_warn_i;
      flags_q.clip     <= |clip_i;
    end
  end

  assign flags_o = flags_q;

  p_clip_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clip_i) |=> flags_q.clip);
  p_sd_self_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ot_sd_i |=> !flags_q.shutdown);
endmodule

// File: rtl/amp_prot_ctrl.sv
module amp_prot_ctrl
  import amp_prot_pkg::*;
#(
  parameter int unsigned NUM_CH        = DEF_NUM_CH,
  parameter int unsigned RECOVER_TICKS = DEF_WINDOW,
  parameter int unsigned DC_TRIP_TICKS = DEF_WINDOW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              standby_i,
  input  logic [NUM_CH-1:0] oc_peak_i,
  input  logic [NUM_CH-1:0] cbc_lim_i,
  input  logic [NUM_CH-1:0] dc_off_i,
  input  logic [NUM_CH-1:0] clip_i,
  input  logic              ot_warn_i,
  input  logic              ot_sd_i,
  output logic [NUM_CH-1:0] hiz_o,
  output logic              fault_no,
  output logic              clip_warn_no
);
  logic [NUM_CH-1:0] oc_trip;
  logic [NUM_CH-1:0] dc_lat;
  glob_flags_t       gflags;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    prot_oc_chan #(.RECOVER_TICKS(RECOVER_TICKS)) u_oc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .oc_peak_i (oc_peak_i[g]),
      .cbc_i     (cbc_lim_i[g]),
      .trip_o    (oc_trip[g])
    );
    prot_dc_chan #(.TRIP_TICKS(DC_TRIP_TICKS)) u_dc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .standby_i (standby_i),
      .dc_off_i  (dc_off_i[g]),
      .latch_o   (dc_lat[g])
    );
    assign hiz_o[g] = oc_trip[g] | dc_lat[g] | gflags.shutdown;
  end

  prot_global #(.NUM_CH(NUM_CH)) u_glob (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ot_warn_i (ot_warn_i),
    .ot_sd_i   (ot_sd_i),
    .clip_i    (clip_i),
    .flags_o   (gflags)
  );

  // open-drain lines: 0 = pulled low, 1 = released
  assign fault_no     = ~(|oc_trip | |dc_lat | gflags.shutdown);
  assign clip_warn_no = ~(gflags.clip | gflags.warn);

  p_sd_all_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_sd_i |=> (&hiz_o && !fault_no));
  p_hiz_means_fault_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hiz_o) |-> !fault_no);
  p_warn_line_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_warn_i |=> !clip_warn_no);
endmodule

// File: tb/amp_prot_ctrl_test.sv
module amp_prot_ctrl_test;
  localparam int NCH = 4;
  localparam int WIN = 1000;
  localparam int TICK_DIV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic standby = 1'b0;
  logic [NCH-1:0] oc_peak = '0, cbc = '0, dc_off = '0, clip = '0;
  logic ot_warn = 1'b0, ot_sd = 1'b0;
  logic [NCH-1:0] hiz;
  logic fault_n, clip_warn_n;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  amp_prot_ctrl #(.NUM_CH(NCH), .RECOVER_TICKS(WIN), .DC_TRIP_TICKS(WIN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .standby_i(standby),
    .oc_peak_i(oc_peak), .cbc_lim_i(cbc), .dc_off_i(dc_off), .clip_i(clip),
    .ot_warn_i(ot_warn), .ot_sd_i(ot_sd),
    .hiz_o(hiz), .fault_no(fault_n), .clip_warn_no(clip_warn_n)
  );

  int div = 0;
  always @(negedge clk) begin
    div  <= (div == TICK_DIV - 1) ? 0 : div + 1;
    tick <= (div == TICK_DIV - 1);
  end

  // bench model built from the requirements
  logic [NCH-1:0] m_trip, m_latch;
  int m_ocnt [NCH];
  int m_dcnt [NCH];
  logic m_sd, m_warn, m_clip;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_trip <= '0; m_latch <= '0; m_sd <= 0; m_warn <= 0; m_clip <= 0;
      for (int c = 0; c < NCH; c++) begin m_ocnt[c] <= 0; m_dcnt[c] <= 0; end
    end else begin
      m_sd <= ot_sd; m_warn <= ot_warn; m_clip <= |clip;
      for (int c = 0; c < NCH; c++) begin
        if (oc_peak[c]) begin m_trip[c] <= 1; m_ocnt[c] <= 0; end
        else if (m_trip[c] && tick) begin
          if (m_ocnt[c] == WIN - 1) begin m_trip[c] <= 0; m_ocnt[c] <= 0; end
          else m_ocnt[c] <= m_ocnt[c] + 1;
        end
        if (standby) begin m_latch[c] <= 0; m_dcnt[c] <= 0; end
        else if (!dc_off[c]) m_dcnt[c] <= 0;
        else if (!m_latch[c] && tick) begin
          if (m_dcnt[c] == WIN - 1) begin m_latch[c] <= 1; m_dcnt[c] <= 0; end
          else m_dcnt[c] <= m_dcnt[c] + 1;
        end
      end
    end
  end

  function automatic logic [NCH-1:0] exp_hiz();
    return m_trip | m_latch | {NCH{m_sd}};
  endfunction
  function automatic logic exp_fault_n();
    return ~(|m_trip | |m_latch | m_sd);
  endfunction
  function automatic logic exp_cw_n();
    return ~(m_clip | m_warn);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int seen = 0;
    while (seen < n) begin
      @(posedge clk);
      if (tick) seen++;
    end
    @(negedge clk);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R10 reset state
    chk("R10 hiz", 32'(hiz), 0);
    chk("R10 fault_no", 32'(fault_n), 1);
    chk("R10 clip_warn_no", 32'(clip_warn_n), 1);

    // R1 single-channel trip
    oc_peak = 4'b0010; step(1); oc_peak = '0;
    chk("R1 hiz", 32'(hiz), 32'h2);
    chk("R9 fault_no oc", 32'(fault_n), 0);
    // R2 restart halfway
    wait_ticks(500);
    oc_peak = 4'b0010; step(1); oc_peak = '0;
    wait_ticks(WIN - 1);
    chk("R2 still tripped", 32'(hiz[1]), 1);
    wait_ticks(1);
    chk("R2 recovered", 32'(hiz[1]), 0);
    chk("R2 fault released", 32'(fault_n), 1);

    // R3 cycle-by-cycle limit
    cbc = '1; step(100);
    chk("R3 hiz", 32'(hiz), 0);
    chk("R3 fault_no", 32'(fault_n), 1);
    cbc = '0;

    // R4 DC window with a gap
    dc_off[2] = 1; wait_ticks(WIN - 1);
    chk("R4 before window", 32'(hiz[2]), 0);
    dc_off[2] = 0; step(1); dc_off[2] = 1;
    wait_ticks(WIN - 1);
    chk("R4 gap reset count", 32'(hiz[2]), 0);
    wait_ticks(1);
    chk("R4 latched", 32'(hiz), 32'h4);
    chk("R4 fault_no", 32'(fault_n), 0);
    // R5 latch holds without offset
    dc_off[2] = 0; wait_ticks(2 * WIN);
    chk("R5 holds", 32'(hiz[2]), 1);
    dc_off[2] = 1; standby = 1; step(2); standby = 0; step(1);
    chk("R5 standby clears", 32'(hiz[2]), 0);
    wait_ticks(WIN - 1);
    chk("R5 no early retrip", 32'(hiz[2]), 0);
    wait_ticks(1);
    chk("R5 retrip", 32'(hiz[2]), 1);
    standby = 1; dc_off[2] = 0; step(2); standby = 0; step(1);
    chk("R5 cleared again", 32'(hiz), 0);

    // R6 clip
    clip = 4'b1000; step(1);
    chk("R6 clip low", 32'(clip_warn_n), 0);
    clip = '0; step(1);
    chk("R6 clip release", 32'(clip_warn_n), 1);

    // R7 warning
    ot_warn = 1; step(1);
    chk("R7 warn low", 32'(clip_warn_n), 0);
    chk("R7 no fault", 32'(fault_n), 1);
    chk("R7 no hiz", 32'(hiz), 0);
    ot_warn = 0; step(1);
    chk("R7 warn release", 32'(clip_warn_n), 1);

    // R8 shutdown, R9 fault combination
    oc_peak = 4'b0001; ot_sd = 1; step(1); oc_peak = '0;
    chk("R8 all hiz", 32'(hiz), 32'hF);
    chk("R8 fault_no", 32'(fault_n), 0);
    ot_sd = 0; step(1);
    chk("R8 auto return", 32'(hiz), 32'h1);
    chk("R9 oc keeps fault", 32'(fault_n), 0);
    wait_ticks(WIN);
    chk("R9 fault released", 32'(fault_n), 1);

    // random phase against model
    for (int cyc = 0; cyc < 60000; cyc++) begin
      for (int c = 0; c < NCH; c++) begin
        oc_peak[c] = ($urandom % 3000) == 0;
        if (($urandom % 2000) == 0) dc_off[c] = ~dc_off[c];
        clip[c] = ($urandom % 8) == 0;
        cbc[c]  = ($urandom % 4) == 0;
      end
      if (($urandom % 500) == 0) ot_warn = ~ot_warn;
      if (($urandom % 4000) == 0) ot_sd = ~ot_sd;
      standby = ($urandom % 5000) == 0;
      step(1);
      if (cyc % 64 == 0) begin
        chk("R1 R4 R8 random hiz", 32'(hiz), 32'(exp_hiz()));
        chk("R9 random fault_no", 32'(fault_n), 32'(exp_fault_n()));
        chk("R6 R7 random clip_warn_no", 32'(clip_warn_n), 32'(exp_cw_n()));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule